// File: doc/BRIEF.md
# Framed Four-Bit Pattern Detector

This block takes a serial bit stream, one bit per clock, and cuts it into fixed groups of four bits that follow one another with no overlap. When the group that is ending matches one of two fixed patterns, it raises a one-cycle flag. The flag is a Mealy output, so it rises in the same cycle in which the last bit of the group is on the input. After the fourth bit the machine goes back to its starting state, whatever that bit was. A pattern that spans two groups is therefore never seen.

Internally the block is an eight-state machine built from D flip-flops. Its next-state logic and its flag logic are separate combinational blocks. Prefixes that can no longer match are collapsed into shared dead states. The two live three-bit prefixes (0,1,0 and 1,0,0) have the same future, so they share one state.

The reset is active-low and asynchronous. It passes through a two-stage synchronizer, so the machine is cleared at once when reset goes low and leaves reset on a clock edge.

Top module: `framed_pattern_detector`

## Requirements
- R1: `z_out` is 1 while the fourth bit of a group is present, if the group's bits in arrival order are 0,1,0,1 or 1,0,0,1. Taken with the first-arrived bit as the MSB, these are the values 4'b0101 and 4'b1001.
- R2: After every fourth bit the machine returns to its group-start state, whatever that bit was. The next bit is bit 1 of a new group, and matching groups placed back to back each raise the flag.
- R3: `z_out` is 0 in the first three bit cycles of every group, and in the fourth bit cycle of any group whose value is not one of the two patterns.
- R4: The flag is a Mealy output. In a fourth-bit cycle after a live prefix, changing `x_in` from 0 to 1 before the clock edge takes `z_out` from 0 to 1 within the same cycle.
- R5: Four bits that form a pattern but cross a group boundary raise no flag.
- R6: After reset, feeding the sixteen bits 0101 0010 1001 0100 gives `z_out` = 1 only at bit times 3 and 11, counting from 0.
- R7: Driving `rst_n` low clears the machine to group start at once, so `z_out` is 0 even with `x_in` = 1. Two clock edges after `rst_n` rises, the next bit is bit 1 of a new group.
- R8: The prefixes 0,1,0 and 1,0,0 act as one state: in both cases a final 1 raises the flag and a final 0 does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| x_in | input | 1 | Serial data bit |
| z_out | output | 1 | Mealy match flag for the group that is ending |

## Verification
Two things happen in the last bit cycle of a matching group: the flag is raised from the live input, and the machine wraps back to group start. The bench puts matching groups back to back, so the cycle right after each flag must already act as bit 1 of a new group. The model that judges this only counts bit positions modulo four and keeps the last four bits. The bench also toggles the input inside a single fourth-bit cycle to show the flag following it before the edge. It asserts reset partway through a group to show the frame count starting over.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int FRAME_LEN = 4;
  localparam int POS_W     = $clog2(FRAME_LEN);

  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_P0    = 3'd1,
    ST_P1    = 3'd2,
    ST_P01   = 3'd3,
    ST_P10   = 3'd4,
    ST_DEAD2 = 3'd5,
    ST_LIVE3 = 3'd6,
    ST_DEAD3 = 3'd7
  } fpd_state_e;
endpackage

// File: rtl/fpd_rst_sync.sv
module fpd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[i] <= 1'b0;
          else         chain_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/fpd_next_state.sv
module fpd_next_state
  import fpd_pkg::*;
(
  input  fpd_state_e cur_state,
  input  logic       bit_in,
  output fpd_state_e nxt_state
);
  always_comb begin
    nxt_state = ST_START;
    unique case (cur_state)
      ST_START: nxt_state = bit_in ? ST_P1    : ST_P0;
      ST_P0:    nxt_state = bit_in ? ST_P01   : ST_DEAD2;
      ST_P1:    nxt_state = bit_in ? ST_DEAD2 : ST_P10;
      ST_P01:   nxt_state = bit_in ? ST_DEAD3 : ST_LIVE3;
      ST_P10:   nxt_state = bit_in ? ST_DEAD3 : ST_LIVE3;
      ST_DEAD2: nxt_state = ST_DEAD3;
      ST_LIVE3: nxt_state = ST_START;
      ST_DEAD3: nxt_state = ST_START;
      default:  nxt_state = ST_START;
    endcase
  end
endmodule

// File: rtl/fpd_flag_logic.sv
module fpd_flag_logic
  import fpd_pkg::*;
(
  input  fpd_state_e cur_state,
  input  logic       bit_in,
  output logic       flag
);
  always_comb begin
    flag = 1'b0;
    if (cur_state == ST_LIVE3) flag = bit_in;
  end
endmodule

// File: rtl/framed_pattern_detector.sv
module framed_pattern_detector
  import fpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x_in,
  output logic z_out
);
  logic       srst_n;
  fpd_state_e state_q;
  fpd_state_e state_d;
  logic       flag;

  fpd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  fpd_next_state u_next (
    .cur_state (state_q),
    .bit_in    (x_in),
    .nxt_state (state_d)
  );

  fpd_flag_logic u_flag (
    .cur_state (state_q),
    .bit_in    (x_in),
    .flag      (flag)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= ST_START;
    else         state_q <= state_d;
  end

  assign z_out = flag;

  // Independent frame position counter used only by the checks below.
  logic [POS_W-1:0] chk_pos_q;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) chk_pos_q <= '0;
    else         chk_pos_q <= chk_pos_q + 1'b1;
  end

  // R2: every group boundary lands on the start state
  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (chk_pos_q == '0) |-> (state_q == ST_START));

  // R3: a flag is only ever raised on the fourth bit of a group
  assert_flag_fourth_only_R3: assert property (@(posedge clk) disable iff (!srst_n)
    z_out |-> (chk_pos_q == POS_W'(FRAME_LEN-1)));

  // R1: both patterns end in 1, so a flag needs a high input bit
  assert_flag_needs_one_R1: assert property (@(posedge clk) disable iff (!srst_n)
    z_out |-> x_in);

  // R8: the merged live state is reached only from the two live two-bit prefixes
  assert_live3_origin_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == ST_LIVE3) |-> ($past(state_q) == ST_P01 || $past(state_q) == ST_P10));

  // R7: while the reset is held the flag stays low
  always_comb begin
    if (!srst_n) assert_reset_quiet_R7: assert (!z_out);
  end
endmodule

// File: tb/framed_pattern_detector_tb.sv
`timescale 1ns/1ps
module framed_pattern_detector_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic x_in;
  logic z_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  int       ref_pos;
  logic [2:0] ref_sh;

  always #2.5 clk = ~clk;

  framed_pattern_detector u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .x_in  (x_in),
    .z_out (z_out)
  );

  function automatic logic model_flag(input int pos, input logic [2:0] sh, input logic b);
    logic [3:0] grp;
    grp = {sh, b};
    return (pos == 3) && (grp == 4'b0101 || grp == 4'b1001);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s z_out=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic b);
    ref_sh  = {ref_sh[1:0], b};
    ref_pos = (ref_pos + 1) % 4;
  endtask

  task automatic drive_bit(input logic b, input string tag);
    @(negedge clk);
    x_in = b;
    #1;
    check(z_out, model_flag(ref_pos, ref_sh, b), tag);
    model_step(b);
  endtask

  task automatic drive_group(input logic [3:0] g, input string tag);
    for (int i = 3; i >= 0; i--) drive_bit(g[i], tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    x_in  = 1'b1;
    #1;
    check(z_out, 1'b0, "R7 reset held");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    ref_pos = 0;
    ref_sh  = 3'b000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] trace;
    int unsigned seed;
    rst_n   = 1'b0;
    x_in    = 1'b0;
    ref_pos = 0;
    ref_sh  = 3'b000;
    seed    = 32'd4242;
    void'($urandom(seed));
    do_reset();

    // R6: stated trace, bit time 0 is the MSB
    trace = 16'b0101_0010_1001_0100;
    for (int t = 0; t < 16; t++) begin
      @(negedge clk);
      x_in = trace[15-t];
      #1;
      check(z_out, (t == 3 || t == 11), "R6 trace");
      model_step(trace[15-t]);
    end

    // R1 / R3: every group value
    for (int v = 0; v < 16; v++) drive_group(4'(v), "R1/R3 sweep");

    // R2: matching groups back to back
    drive_group(4'b1001, "R2 back-to-back");
    drive_group(4'b0101, "R2 back-to-back");
    drive_group(4'b1001, "R2 back-to-back");

    // R5: 0,1,0,1 crosses the group boundary
    drive_group(4'b1110, "R5 straddle");
    drive_group(4'b1011, "R5 straddle");

    // R8: both merged prefixes, both final bits
    drive_group(4'b0100, "R8 prefix010 end0");
    drive_group(4'b1000, "R8 prefix100 end0");
    drive_group(4'b0101, "R8 prefix010 end1");
    drive_group(4'b1001, "R8 prefix100 end1");

    // R4: flag follows the input inside the fourth-bit cycle
    drive_bit(1'b0, "R4 prefix");
    drive_bit(1'b1, "R4 prefix");
    drive_bit(1'b0, "R4 prefix");
    @(negedge clk);
    x_in = 1'b0;
    #0.5;
    check(z_out, 1'b0, "R4 low input");
    x_in = 1'b1;
    #0.5;
    check(z_out, 1'b1, "R4 high input");
    model_step(1'b1);

    // R7: reset in the middle of a group restarts the frame count
    drive_bit(1'b1, "R7 pre-reset");
    drive_bit(1'b0, "R7 pre-reset");
    do_reset();
    drive_group(4'b1001, "R7 after reset");
    drive_group(4'b0101, "R7 after reset");

    // R3: long random run
    for (int n = 0; n < 4000; n++) drive_bit(1'($urandom), "R3 random");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule